// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block sits beside a 32-bit processor core and watches for debug breakpoints. Each cycle it may see the address of the instruction about to execute and the effective address of a load or store. Both are compared against programmable base and mask registers. The comparison ignores address bits whose mask bit is clear. A control register decides which kinds of hit count.

When a counted hit occurs, the unit sets sticky status flags in the control register. In the next cycle it pulses a one-cycle request toward the exception logic. Software programs the unit through a simple write port. It can read back the control word, status flags included, on a dedicated output.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset the control word reads 0 and `bp_req` is low. With the address and mask registers still zero, no access raises a hit.
- R2: A write with `cfg_wr_sel` = 0 updates only the control bits in mask 0xFF80F03F. Every other bit keeps its old value, which is 0.
- R3: `cfg_wr_sel` = 1 writes the code base register and `cfg_wr_sel` = 2 writes the code mask register. A fetch hits when ((fetch_addr XOR base) AND mask) is zero and the mask is non-zero.
- R4: A code or data mask register holding zero never produces a hit, even when the address equals the base.
- R5: Code hits count only when control bits 23, 24 and 31 are all set.
- R6: `cfg_wr_sel` = 3 writes the data base register and `cfg_wr_sel` = 4 writes the data mask register. Data hits use the same XOR-and-mask rule. Loads count only when control bits 23, 25, 26 and 31 are set. Stores count only when bits 23, 25, 27 and 31 are set.
- R7: A code hit sets control bits 0 (any) and 1 (code). A data hit sets bit 0, bit 2 (data), and either bit 3 (load) or bit 4 (store). The flags stay set until a control write clears them.
- R8: A store flagged as sub-word is compared using its address with the low two bits cleared. Every other access, including a load flagged as sub-word, is compared using its full address.
- R9: When a code hit and a data hit occur in the same cycle, a single request is raised and only the code flags are set.
- R10: A counted hit raises `bp_req` for exactly the next cycle, and the status flags are visible in that same cycle. A hit in the same cycle as a control write sets its flags on top of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select: 0 control, 1 code base, 2 code mask, 3 data base, 4 data mask |
| cfg_wr_data | input | 32 | Register write data |
| fetch_valid | input | 1 | An instruction is about to execute |
| fetch_addr | input | AW | Address of that instruction |
| dacc_valid | input | 1 | A load or store is issued |
| dacc_write | input | 1 | 1 = store, 0 = load |
| dacc_sub_word_store | input | 1 | Store is a partial-word (unaligned-merge) store |
| dacc_addr | input | AW | Effective address of the access |
| bp_req | output | 1 | One-cycle breakpoint request |
| ctrl_o | output | 32 | Current control word including status flags |

## Verification
The hardest situation to reach from the ports is a code hit and a data hit landing in one cycle. Both comparators must be primed and all the enables set, and the fetch and the access must then be presented together. The bench does this directly, and it also runs a long pseudo-random phase. In that phase the address pools are kept small so that both hit types coincide often, sometimes while a control write is also under way. The enable gating is swept over all 64 combinations of the six enable bits, and each combination is tried with a fetch, a load and a store.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
   localparam int CTRL_W = 32;

   // register select codes on the write port
   localparam logic [2:0] SEL_CTRL      = 3'd0;
   localparam logic [2:0] SEL_CODE_BASE = 3'd1;
   localparam logic [2:0] SEL_CODE_MASK = 3'd2;
   localparam logic [2:0] SEL_DATA_BASE = 3'd3;
   localparam logic [2:0] SEL_DATA_MASK = 3'd4;

   localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'hFF80_F03F;

   // status flag positions
   localparam int ST_ANY   = 0;
   localparam int ST_CODE  = 1;
   localparam int ST_DATA  = 2;
   localparam int ST_LOAD  = 3;
   localparam int ST_STORE = 4;
   localparam int ST_NUM   = 5;

   // enable positions
   localparam int EN_MASTER_LO = 23;
   localparam int EN_CODE      = 24;
   localparam int EN_DATA      = 25;
   localparam int EN_LOAD      = 26;
   localparam int EN_STORE     = 27;
   localparam int EN_MASTER_HI = 31;

   // comparator channels
   localparam int CH_CODE = 0;
   localparam int CH_DATA = 1;
   localparam int CH_NUM  = 2;

   function automatic logic [2:0] base_sel(input int ch);
      return (ch == CH_CODE) ? SEL_CODE_BASE : SEL_DATA_BASE;
   endfunction

   function automatic logic [2:0] mask_sel(input int ch);
      return (ch == CH_CODE) ? SEL_CODE_MASK : SEL_DATA_MASK;
   endfunction
endpackage

// File: rtl/bkpt_addr_cmp.sv
module bkpt_addr_cmp #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] probe_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] mask_i,
   output logic          hit_o
);
   logic [AW-1:0] diff;

   always_comb begin
      diff  = (probe_i ^ base_i) & mask_i;
      hit_o = (|mask_i) && !(|diff);
   end
endmodule

// File: rtl/bkpt_addr_regs.sv
module bkpt_addr_regs
   import bkpt_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [2:0]                wr_sel_i,
   input  logic [CTRL_W-1:0]         wr_data_i,
   output logic [CH_NUM-1:0][AW-1:0] base_o,
   output logic [CH_NUM-1:0][AW-1:0] mask_o
);
   for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_ch
      logic [AW-1:0] base_r;
      logic [AW-1:0] mask_r;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_r <= '0;
            mask_r <= '0;
         end else if (wr_en_i) begin
            if (wr_sel_i == base_sel(ch)) base_r <= wr_data_i[AW-1:0];
            if (wr_sel_i == mask_sel(ch)) mask_r <= wr_data_i[AW-1:0];
         end
      end

      assign base_o[ch] = base_r;
      assign mask_o[ch] = mask_r;
   end
endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
   import bkpt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CTRL_W-1:0] wr_data_i,
   input  logic              set_code_i,
   input  logic              set_load_i,
   input  logic              set_store_i,
   output logic              code_on_o,
   output logic              load_on_o,
   output logic              store_on_o,
   output logic [CTRL_W-1:0] ctrl_o
);
   logic [CTRL_W-1:0] ctrl_q;
   logic [CTRL_W-1:0] ctrl_d;
   logic              master_on;

   always_comb begin
      master_on  = ctrl_q[EN_MASTER_LO] & ctrl_q[EN_MASTER_HI];
      code_on_o  = master_on & ctrl_q[EN_CODE];
      load_on_o  = master_on & ctrl_q[EN_DATA] & ctrl_q[EN_LOAD];
      store_on_o = master_on & ctrl_q[EN_DATA] & ctrl_q[EN_STORE];
   end

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_i) ctrl_d = (ctrl_q & ~CTRL_WMASK) | (wr_data_i & CTRL_WMASK);
      if (set_code_i) begin
         ctrl_d[ST_ANY]  = 1'b1;
         ctrl_d[ST_CODE] = 1'b1;
      end
      if (set_load_i || set_store_i) begin
         ctrl_d[ST_ANY]  = 1'b1;
         ctrl_d[ST_DATA] = 1'b1;
      end
      if (set_load_i)  ctrl_d[ST_LOAD]  = 1'b1;
      if (set_store_i) ctrl_d[ST_STORE] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   assign ctrl_o = ctrl_q;

   for (genvar f = 0; f < ST_NUM; f++) begin : g_sticky
      // R7
      sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_q[f] && !wr_i) |=> ctrl_q[f]);
   end

   // R2
   always @(posedge clk) begin
      if (rst_n) rsvd_zero_chk: assert ((ctrl_q & ~CTRL_WMASK) == '0);
   end

   // R9
   prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctrl_q[ST_CODE]) && !$past(wr_i)) |-> !$rose(ctrl_q[ST_DATA]));
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
   import bkpt_pkg::*;
#(
   parameter int AW         = 32,
   parameter int ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [2:0]        cfg_wr_sel,
   input  logic [CTRL_W-1:0] cfg_wr_data,
   input  logic              fetch_valid,
   input  logic [AW-1:0]     fetch_addr,
   input  logic              dacc_valid,
   input  logic              dacc_write,
   input  logic              dacc_sub_word_store,
   input  logic [AW-1:0]     dacc_addr,
   output logic              bp_req,
   output logic [CTRL_W-1:0] ctrl_o
);
   localparam logic [AW-1:0] LOW_ONES = AW'((64'd1 << ALIGN_BITS) - 64'd1);

   if (AW > CTRL_W || AW <= ALIGN_BITS) begin : g_bad_cfg
      $error("bkpt_match_unit: AW must exceed ALIGN_BITS and fit the write port");
   end

   logic [CH_NUM-1:0][AW-1:0] base;
   logic [CH_NUM-1:0][AW-1:0] mask;
   logic [CH_NUM-1:0][AW-1:0] probe;
   logic [CH_NUM-1:0]         raw_hit;
   logic code_on, load_on, store_on;
   logic code_evt, data_evt, wr_ctrl;
   logic req_q;

   assign wr_ctrl = cfg_wr_en && (cfg_wr_sel == SEL_CTRL);

   bkpt_addr_regs #(.AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (cfg_wr_en),
      .wr_sel_i  (cfg_wr_sel),
      .wr_data_i (cfg_wr_data),
      .base_o    (base),
      .mask_o    (mask)
   );

   always_comb begin
      probe[CH_CODE] = fetch_addr;
      probe[CH_DATA] = (dacc_write && dacc_sub_word_store) ? (dacc_addr & ~LOW_ONES) : dacc_addr;
   end

   for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_cmp
      bkpt_addr_cmp #(.AW(AW)) u_cmp (
         .probe_i (probe[ch]),
         .base_i  (base[ch]),
         .mask_i  (mask[ch]),
         .hit_o   (raw_hit[ch])
      );
   end

   always_comb begin
      code_evt = fetch_valid & code_on & raw_hit[CH_CODE];
      data_evt = dacc_valid & (dacc_write ? store_on : load_on) & raw_hit[CH_DATA] & ~code_evt;
   end

   bkpt_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (wr_ctrl),
      .wr_data_i   (cfg_wr_data),
      .set_code_i  (code_evt),
      .set_load_i  (data_evt & ~dacc_write),
      .set_store_i (data_evt & dacc_write),
      .code_on_o   (code_on),
      .load_on_o   (load_on),
      .store_on_o  (store_on),
      .ctrl_o      (ctrl_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= code_evt | data_evt;
   end

   assign bp_req = req_q;

   // R10
   req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bp_req |-> ctrl_o[ST_ANY]);

   // R5
   codeflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_o[ST_CODE] && !fetch_valid && !wr_ctrl) |=> !ctrl_o[ST_CODE]);
endmodule

// File: tb/bkpt_match_unit_bench.sv
module bkpt_match_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [2:0]  cfg_wr_sel = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        dacc_valid = 1'b0;
   logic        dacc_write = 1'b0;
   logic        dacc_sub_word_store = 1'b0;
   logic [31:0] dacc_addr = '0;
   logic        bp_req;
   logic [31:0] ctrl_o;

   int nvec = 0;
   int nbad = 0;

   logic [31:0] m_ctrl = '0;
   logic [31:0] m_base [2] = '{32'd0, 32'd0};
   logic [31:0] m_mask [2] = '{32'd0, 32'd0};
   logic [31:0] seed = 32'h1234_5678;

   localparam logic [31:0] WMASK   = 32'hFF80_F03F;
   localparam logic [31:0] ALL_EN  = 32'h8F80_0000;
   localparam logic [31:0] CODE_A  = 32'h8000_1230;
   localparam logic [31:0] DATA_A  = 32'h1F80_1000;

   always #4 clk = ~clk;

   bkpt_match_unit u_bkpt_match_unit (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
      .cfg_wr_data(cfg_wr_data), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .dacc_valid(dacc_valid), .dacc_write(dacc_write),
      .dacc_sub_word_store(dacc_sub_word_store), .dacc_addr(dacc_addr),
      .bp_req(bp_req), .ctrl_o(ctrl_o)
   );

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   function automatic logic match(input logic [31:0] a, input logic [31:0] b, input logic [31:0] m);
      return (m != 0) && (((a ^ b) & m) == 0);
   endfunction

   task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] data,
                       input logic fv, input logic [31:0] fa,
                       input logic dv, input logic dw, input logic ds, input logic [31:0] da,
                       input string tag);
      logic c23, c31, code_on, load_on, store_on, eh, dh, exp_req;
      logic [31:0] probe;
      logic [31:0] exp_ctrl;
      cfg_wr_en = we; cfg_wr_sel = sel; cfg_wr_data = data;
      fetch_valid = fv; fetch_addr = fa;
      dacc_valid = dv; dacc_write = dw; dacc_sub_word_store = ds; dacc_addr = da;
      c23 = m_ctrl[23]; c31 = m_ctrl[31];
      code_on  = c23 & c31 & m_ctrl[24];
      load_on  = c23 & c31 & m_ctrl[25] & m_ctrl[26];
      store_on = c23 & c31 & m_ctrl[25] & m_ctrl[27];
      probe = (dw && ds) ? (da & ~32'd3) : da;
      eh = fv && code_on && match(fa, m_base[0], m_mask[0]);
      dh = !eh && dv && (dw ? store_on : load_on) && match(probe, m_base[1], m_mask[1]);
      exp_req = eh | dh;
      exp_ctrl = m_ctrl;
      if (we && sel == 3'd0) exp_ctrl = (m_ctrl & ~WMASK) | (data & WMASK);
      if (eh) exp_ctrl = exp_ctrl | 32'h3;
      if (dh) exp_ctrl = exp_ctrl | 32'h5 | (dw ? 32'h10 : 32'h8);
      if (we && sel == 3'd1) m_base[0] = data;
      if (we && sel == 3'd2) m_mask[0] = data;
      if (we && sel == 3'd3) m_base[1] = data;
      if (we && sel == 3'd4) m_mask[1] = data;
      m_ctrl = exp_ctrl;
      @(negedge clk);
      nvec++;
      if (bp_req !== exp_req || ctrl_o !== exp_ctrl) begin
         nbad++;
         $display("FAIL %s: req=%0b ctrl=%08h expected req=%0b ctrl=%08h",
                  tag, bp_req, ctrl_o, exp_req, exp_ctrl);
      end
      cfg_wr_en = 1'b0; fetch_valid = 1'b0; dacc_valid = 1'b0;
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data, input string tag);
      step(1'b1, sel, data, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, tag);
   endtask

   task automatic fetch(input logic [31:0] a, input string tag);
      step(1'b0, '0, '0, 1'b1, a, 1'b0, 1'b0, 1'b0, '0, tag);
   endtask

   task automatic dacc(input logic w, input logic s, input logic [31:0] a, input string tag);
      step(1'b0, '0, '0, 1'b0, '0, 1'b1, w, s, a, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog (all requirements): run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      nvec++;
      if (bp_req !== 1'b0 || ctrl_o !== 32'd0) begin
         nbad++;
         $display("FAIL R1: req=%0b ctrl=%08h expected req=0 ctrl=00000000", bp_req, ctrl_o);
      end
      fetch(32'd0, "R1 zero regs fetch");
      dacc(1'b0, 1'b0, 32'd0, "R1 zero regs load");

      // R2 write mask
      wr(3'd0, 32'hFFFF_FFFF, "R2 all ones");
      wr(3'd0, 32'h007F_0FC0, "R2 unmasked bits");
      wr(3'd0, 32'h0000_0000, "R2 clear");

      wr(3'd1, CODE_A, "R3 code base");
      wr(3'd2, 32'hFFFF_FFF0, "R3 code mask");
      wr(3'd3, DATA_A, "R6 data base");
      wr(3'd4, 32'hFFFF_F000, "R6 data mask");

      // R5 / R6 enable sweep over bits 23,24,25,26,27,31
      for (int c = 0; c < 64; c++) begin
         logic [31:0] v;
         v = {c[5], 3'b000, c[4:0], 23'd0};
         wr(3'd0, v, "R5 set enables");
         fetch(CODE_A + 32'd4, "R5 gated fetch");
         wr(3'd0, v, "R7 clear flags");
         dacc(1'b0, 1'b0, DATA_A + 32'hABC, "R6 gated load");
         wr(3'd0, v, "R7 clear flags");
         dacc(1'b1, 1'b0, DATA_A + 32'h123, "R6 gated store");
      end

      // R3 address sweeps
      wr(3'd0, ALL_EN, "R3 enable all");
      for (int i = 0; i < 64; i++) begin
         wr(3'd0, ALL_EN, "R7 clear flags");
         fetch(32'h8000_1200 + 32'(i) * 4, "R3 fetch sweep");
      end
      for (int b = 0; b < 32; b++) begin
         wr(3'd0, ALL_EN, "R7 clear flags");
         fetch((CODE_A + 32'd4) ^ (32'd1 << b), "R3 single bit flip");
      end
      for (int b = 0; b < 32; b++) begin
         wr(3'd0, ALL_EN, "R7 clear flags");
         dacc(b[0], 1'b0, (DATA_A + 32'h55) ^ (32'd1 << b), "R6 single bit flip");
      end

      // R4 zero masks
      wr(3'd0, ALL_EN, "R7 clear flags");
      wr(3'd2, 32'd0, "R4 code mask zero");
      fetch(CODE_A, "R4 code exact address");
      wr(3'd4, 32'd0, "R4 data mask zero");
      dacc(1'b0, 1'b0, DATA_A, "R4 data exact load");
      dacc(1'b1, 1'b0, DATA_A, "R4 data exact store");
      wr(3'd2, 32'hFFFF_FFF0, "R3 code mask");

      // R8 sub-word stores
      wr(3'd4, 32'hFFFF_FFFF, "R8 exact data mask");
      dacc(1'b1, 1'b1, DATA_A + 32'd2, "R8 sub-word store aligned");
      wr(3'd0, ALL_EN, "R7 clear flags");
      dacc(1'b1, 1'b1, DATA_A + 32'd3, "R8 sub-word store aligned");
      wr(3'd0, ALL_EN, "R7 clear flags");
      dacc(1'b0, 1'b1, DATA_A + 32'd2, "R8 sub-word load unaligned");
      dacc(1'b1, 1'b0, DATA_A + 32'd2, "R8 normal store unaligned");
      dacc(1'b0, 1'b0, DATA_A, "R8 normal load exact");

      // R9 simultaneous hits
      wr(3'd0, ALL_EN, "R7 clear flags");
      step(1'b0, '0, '0, 1'b1, CODE_A, 1'b1, 1'b1, 1'b0, DATA_A, "R9 code and store");
      wr(3'd0, ALL_EN, "R7 clear flags");
      step(1'b0, '0, '0, 1'b1, CODE_A, 1'b1, 1'b0, 1'b0, DATA_A, "R9 code and load");
      step(1'b0, '0, '0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, DATA_A, "R9 data only");

      // R7 / R10 stickiness and timing
      fetch(32'h0, "R10 request drops after one cycle");
      fetch(32'h0, "R7 flags held");
      wr(3'd0, ALL_EN, "R7 software clear");
      step(1'b1, 3'd0, ALL_EN, 1'b1, CODE_A, 1'b0, 1'b0, 1'b0, '0, "R10 hit during clear");
      step(1'b1, 3'd0, ALL_EN, 1'b0, '0, 1'b1, 1'b1, 1'b0, DATA_A, "R10 store hit during clear");

      // random mixed traffic (R3, R6, R7, R9 together)
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r, r2, d;
         logic [2:0] sel;
         seed = next_rand(seed); r = seed;
         seed = next_rand(seed); r2 = seed;
         sel = (r[2:0] > 3'd4) ? 3'd0 : r[2:0];
         case (r2[2:0])
            3'd0: d = 32'd0;
            3'd1: d = 32'hFFFF_FFFF;
            3'd2: d = 32'hFFFF_FFF0;
            3'd3: d = 32'h0000_000F;
            default: d = (sel == 3'd1) ? CODE_A : (sel == 3'd3) ? DATA_A : 32'hFFFF_FFFC;
         endcase
         if (sel == 3'd0) d = r2[3] ? ((r2 | ALL_EN) & ~32'h1F) : r2;
         step(r[5:3] == 3'd0, sel, d,
              r[6], CODE_A ^ {26'd0, r[13:8]},
              r[7], r[14], r[15], DATA_A ^ {27'd0, r[20:16]},
              "R6 R9 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule